// File: doc/BRIEF.md
# Serial Challenge-Response Security Engine

This block is a small serial security responder. A host drives an active-low select line, a serial clock and a serial data bit. On every falling edge of the serial clock, the block returns one bit of an 8-bit internal state. When the host's bit is zero, it then scrambles that state with a key-dependent linear mix. An 8-byte transform table, written through a plain write port, sets which mix is used. From this table the block derives a 64-entry coefficient array, one coefficient for each pair of bit index and state bit.

The serial inputs are asynchronous to the system clock. They pass through a synchroniser before any edge is detected. Each table write starts a sequential fill of the coefficient array, which takes 64 system clocks. Serial steps are dropped while the fill runs. Pulling select low restarts the exchange from a fixed seed.

Top module: `secEngine`

## Requirements
- R1: After reset, `sdo` is 1 and `busy` is 0.
- R2: When the synchronised select changes from high to low, the state becomes 0xFC and the bit index becomes 0.
- R3: While select is high, `sdo` is 1 and serial clock edges are not acted on.
- R4: A table write (`tblWe` high, with `tblAddr` choosing the entry) raises `busy` on the next clock edge. `busy` then stays high for exactly 64 clocks after the last write.
- R5: A step happens only when the synchronised serial clock goes from high to low. A rising edge changes nothing.
- R6: When a step begins at bit index 0, the state is first replaced by the XOR of the rows {0xFF, 0xFE, 0xFC, 0xF8, 0xF0, 0xE0, 0xC0, 0x7F}. Row i is included when state bit i is 1.
- R7: The bit returned on `sdo` is the state bit at the current bit index, taken after any R6 mix. It stays on `sdo` until the next step.
- R8: When the serial input bit is 1, the state is left unchanged by the step. When it is 0, the state becomes the XOR of coef(index, i) over every state bit i that is 1.
- R9: coef(0,b) is table entry b. For s>0, take r = coef(s-1,(b-1) mod 8) and set r = {r[6:0], r[7]^r[6]}. When b is 7, r is also XORed with coef(s,0).
- R10: The bit index advances by one, modulo 8, after every step.
- R11: A falling serial clock edge while `busy` is high is ignored: neither the state nor the bit index nor `sdo` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tblWe | input | 1 | Transform table write strobe |
| tblAddr | input | 3 | Table entry index |
| tblData | input | 8 | Table entry value |
| selN | input | 1 | Active-low select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Coefficient fill in progress |

## Verification
The bench builds the block with a three-stage synchroniser. This shows that the edge timing does not depend on the default depth, as long as each serial level is held longer than the synchroniser delay. With slow serial timing, every bit index and every coefficient row is reached by sequences of ones, zeros and mixed bits. The bench also exercises a restart part-way through a sequence and a table rewrite in the middle of an exchange. That rewrite lets it send a falling edge inside the 64-cycle fill window.

// File: rtl/secEnginePkg.sv
package secEnginePkg;
  localparam int SEC_W  = 8;
  localparam int IDX_W  = $clog2(SEC_W);
  localparam int COEF_N = SEC_W * SEC_W;
  localparam int FILL_W = $clog2(COEF_N);
  localparam logic [SEC_W-1:0] SEED = 8'hFC;

  typedef struct packed {
    logic              restart;
    logic              step;
    logic              din;
    logic              fillEn;
    logic [FILL_W-1:0] fillIdx;
    logic              selActive;
  } secStrobes_t;

  // row i of the fixed pre-mix applied at bit index 0
  function automatic logic [SEC_W-1:0] preMixRow(input int i);
    if (i == SEC_W - 1) return {1'b0, {(SEC_W-1){1'b1}}};
    return {SEC_W{1'b1}} << i;
  endfunction
endpackage

// File: rtl/secCtrl.sv
module secCtrl
  import secEnginePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        tblWe,
  output secStrobes_t strobes,
  output logic        busy
);
  logic [SYNC_STAGES-1:0] clkSync, dinSync, selSync;
  logic prevClk, prevSelN;
  logic [FILL_W-1:0] fillIdx;
  logic clkNow, selNow, fallEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      dinSync  <= '1;
      selSync  <= '1;
      prevClk  <= 1'b0;
      prevSelN <= 1'b1;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], sclk};
      dinSync  <= {dinSync[SYNC_STAGES-2:0], sdi};
      selSync  <= {selSync[SYNC_STAGES-2:0], selN};
      prevClk  <= clkNow;
      prevSelN <= selNow;
    end
  end

  assign clkNow   = clkSync[SYNC_STAGES-1];
  assign selNow   = selSync[SYNC_STAGES-1];
  assign fallEdge = prevClk & ~clkNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      fillIdx <= '0;
    end else if (tblWe) begin
      busy    <= 1'b1;
      fillIdx <= '0;
    end else if (busy) begin
      fillIdx <= fillIdx + 1'b1;
      if (fillIdx == FILL_W'(COEF_N - 1)) busy <= 1'b0;
    end
  end

  always_comb begin
    strobes.selActive = ~selNow;
    strobes.restart   = prevSelN & ~selNow;
    strobes.step      = fallEdge & ~selNow & ~busy & ~strobes.restart;
    strobes.din       = dinSync[SYNC_STAGES-1];
    strobes.fillEn    = busy & ~tblWe;
    strobes.fillIdx   = fillIdx;
  end

  a_r4_write_busy: assert property (@(posedge clk) disable iff (!rstN)
    tblWe |=> busy);
  a_r4_fill_end: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tblWe && fillIdx == FILL_W'(COEF_N - 1)) |=> !busy);
endmodule

// File: rtl/secDatapath.sv
module secDatapath
  import secEnginePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tblWe,
  input  logic [IDX_W-1:0] tblAddr,
  input  logic [SEC_W-1:0] tblData,
  input  secStrobes_t      strobes,
  output logic             sdo
);
  logic [SEC_W-1:0] tbl  [SEC_W];
  logic [SEC_W-1:0] coef [COEF_N];
  logic [SEC_W-1:0] stateReg;
  logic [IDX_W-1:0] bitIdx;
  logic             sdoReg;

  // coefficient generation, one entry per cycle in sel-major order
  logic [IDX_W-1:0] fSel, fBit, pSel, pBit;
  logic [SEC_W-1:0] prevCoef, shifted, fillVal;

  assign fSel     = strobes.fillIdx[FILL_W-1:IDX_W];
  assign fBit     = strobes.fillIdx[IDX_W-1:0];
  assign pSel     = fSel - 1'b1;
  assign pBit     = fBit - 1'b1;
  assign prevCoef = coef[{pSel, pBit}];
  assign shifted  = {prevCoef[SEC_W-2:0], prevCoef[SEC_W-1] ^ prevCoef[SEC_W-2]};

  always_comb begin
    if (fSel == '0)
      fillVal = tbl[fBit];
    else if (fBit == IDX_W'(SEC_W - 1))
      fillVal = shifted ^ coef[{fSel, {IDX_W{1'b0}}}];
    else
      fillVal = shifted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SEC_W; i++) tbl[i] <= '0;
      for (int i = 0; i < COEF_N; i++) coef[i] <= '0;
    end else begin
      if (tblWe) tbl[tblAddr] <= tblData;
      if (strobes.fillEn) coef[strobes.fillIdx] <= fillVal;
    end
  end

  // step datapath
  logic [SEC_W-1:0] preMixed, mixed, stepped;

  always_comb begin
    preMixed = '0;
    for (int i = 0; i < SEC_W; i++)
      if (stateReg[i]) preMixed ^= preMixRow(i);
    mixed   = (bitIdx == '0) ? preMixed : stateReg;
    stepped = '0;
    for (int i = 0; i < SEC_W; i++)
      if (mixed[i]) stepped ^= coef[{bitIdx, IDX_W'(i)}];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateReg <= SEED;
      bitIdx   <= '0;
      sdoReg   <= 1'b1;
    end else if (strobes.restart) begin
      stateReg <= SEED;
      bitIdx   <= '0;
      sdoReg   <= 1'b1;
    end else if (strobes.step) begin
      stateReg <= strobes.din ? mixed : stepped;
      bitIdx   <= bitIdx + 1'b1;
      sdoReg   <= mixed[bitIdx];
    end
  end

  assign sdo = strobes.selActive ? sdoReg : 1'b1;

  a_r2_restart_seed: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (stateReg == SEED && bitIdx == '0));
  a_r10_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.restart && !strobes.step) |=> $stable(bitIdx) && $stable(stateReg));
  a_r8_one_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && strobes.din && bitIdx != '0 && !strobes.restart) |=> $stable(stateReg));
endmodule

// File: rtl/secEngine.sv
module secEngine
  import secEnginePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tblWe,
  input  logic [IDX_W-1:0] tblAddr,
  input  logic [SEC_W-1:0] tblData,
  input  logic             selN,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             busy
);
  secStrobes_t strobes;

  secCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdi(sdi),
    .tblWe(tblWe), .strobes(strobes), .busy(busy)
  );

  secDatapath i_dp (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblAddr(tblAddr),
    .tblData(tblData), .strobes(strobes), .sdo(sdo)
  );

  a_r3_desel_high: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.selActive |-> sdo);
endmodule

// File: tb/test_secEngine.sv
module test_secEngine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tblWe = 1'b0;
  logic [2:0] tblAddr = '0;
  logic [7:0] tblData = '0;
  logic selN = 1'b1, sclk = 1'b0, sdi = 1'b1;
  logic sdo, busy;

  int checks = 0, errors = 0;
  logic [7:0] curTbl [8];
  logic [7:0] mState = 8'hFC;
  int mIdx = 0;
  logic lastExp = 1'b1;
  logic expQ [$];
  string tagQ [$];
  event sampleEv;

  secEngine #(.SYNC_STAGES(3)) i_secEngine (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData),
    .selN(selN), .sclk(sclk), .sdi(sdi), .sdo(sdo), .busy(busy)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // R9: coefficient rule, written from the requirement
  function automatic logic [7:0] coefOf(input int s, input int b);
    logic [7:0] r;
    if (s == 0) return curTbl[b];
    r = coefOf(s - 1, (b + 7) % 8);
    r = {r[6:0], r[7] ^ r[6]};
    if (b == 7) r ^= coefOf(s, 0);
    return r;
  endfunction

  // R6, R7, R8, R10 reference step
  function automatic logic modelStep(input logic din);
    logic [7:0] acc;
    logic o;
    if (mIdx == 0) begin
      acc = '0;
      for (int i = 0; i < 8; i++)
        if (mState[i]) acc ^= (i == 7) ? 8'h7F : (8'hFF << i);
      mState = acc;
    end
    o = mState[mIdx];
    if (!din) begin
      acc = '0;
      for (int i = 0; i < 8; i++)
        if (mState[i]) acc ^= coefOf(mIdx, i);
      mState = acc;
    end
    mIdx = (mIdx + 1) % 8;
    return o;
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeTbl(input int a, input logic [7:0] d);
    @(negedge clk);
    tblWe = 1'b1; tblAddr = 3'(a); tblData = d;
    curTbl[a] = d;
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  // driver: one serial bit, pushes the expected sdo
  task automatic sendBit(input logic din, input logic exp, input string tag);
    sdi = din;
    sclk = 1'b1; waitClk(8);
    sclk = 1'b0; waitClk(8);
    expQ.push_back(exp); tagQ.push_back(tag);
    lastExp = exp;
    ->sampleEv;
    #0;
  endtask

  task automatic stepBit(input logic din, input string tag);
    logic o;
    o = modelStep(din);
    sendBit(din, o, tag);
  endtask

  task automatic selectNow();
    selN = 1'b0; waitClk(8);
    mState = 8'hFC; mIdx = 0; lastExp = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() > 0) check(tagQ.pop_front(), sdo, expQ.pop_front());
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pat;
    for (int i = 0; i < 8; i++) curTbl[i] = '0;
    waitClk(3);
    rstN = 1'b1;
    waitClk(1);
    check("R1 sdo", sdo, 1'b1);
    check("R1 busy", busy, 1'b0);

    // R4: load table A, measure fill window
    writeTbl(0, 8'h3A); writeTbl(1, 8'hC5); writeTbl(2, 8'h17); writeTbl(3, 8'h92);
    writeTbl(4, 8'h6E); writeTbl(5, 8'hB1); writeTbl(6, 8'h48);
    @(negedge clk); tblWe = 1'b1; tblAddr = 3'd7; tblData = 8'hDD; curTbl[7] = 8'hDD;
    @(negedge clk); tblWe = 1'b0;
    check("R4 busy_rise", busy, 1'b1);
    waitClk(63);
    check("R4 busy_hold", busy, 1'b1);
    waitClk(1);
    check("R4 busy_fall", busy, 1'b0);

    // R3: deselected, sdo stays 1
    for (int k = 0; k < 4; k++) sendBit(1'(k), 1'b1, "R3 desel");

    // R2 R6 R7 R8 R9 R10: selected sequences
    selectNow();
    check("R2 sdo_after_select", sdo, 1'b1);
    for (int k = 0; k < 16; k++) stepBit(1'(k & 1), "R8 alternating");
    for (int k = 0; k < 8; k++) stepBit(1'b1, "R6 ones");
    for (int k = 0; k < 16; k++) stepBit(1'b0, "R9 zeros");

    // R5: rising edge alone does nothing
    sdi = 1'b0; sclk = 1'b1; waitClk(12);
    check("R5 rise_only", sdo, lastExp);
    sclk = 1'b0; waitClk(8);
    // the fall above is a real step with din 0
    begin
      logic o;
      o = modelStep(1'b0);
      check("R7 after_rise", sdo, o);
      lastExp = o;
    end

    // R2: restart in the middle of a sequence
    selN = 1'b1; waitClk(8);
    check("R3 sdo_deselected", sdo, 1'b1);
    selectNow();
    pat = 16'hB3C6;
    for (int k = 0; k < 16; k++) stepBit(pat[k], "R2 restart_seq");

    // R11: edge during fill is dropped, then continue with the new table
    writeTbl(5, 8'h0F);
    sendBit(1'b0, lastExp, "R11 busy_edge");
    waitClk(64);
    check("R4 fill_done", busy, 1'b0);
    pat = 16'h5A0F;
    for (int k = 0; k < 16; k++) stepBit(pat[k], "R10 post_reload");

    waitClk(4);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual=%0d expected=0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule